// File: doc/BRIEF.md
# Two-Stage System Watchdog Timer

A watchdog peripheral that sits behind a small byte-wide register window. A prescaler divides the system clock into a fixed tick. A down-counter is loaded from a programmable timeout value and decrements once per tick.

When the counter runs out the first time, a timeout flag is raised and the counter reloads itself. If it runs out again before software has cleared that flag, the block records a second timeout. Unless the no-reboot strap is held high, it then issues a one-cycle reset request.

Software services the watchdog by writing to the reload register. Reading that register returns the live count. The window also holds the control, status, mailbox, message and software-interrupt bytes that a platform watchdog of this kind carries.

Top module: `two_stage_watchdog`

## Requirements
- R1: After reset the reload register reads 0x0000, both status halfwords 0x0000, control 1 reads 0x0000, control 2 reads 0x0008, the timeout register reads 0x0004, the software IRQ byte reads 0x03, and the message, mailbox and watchdog-count bytes read 0x00.
- R2: Byte address map: reload 0x00/0x01, data-in 0x02 with data-out 0x03 above it, status 1 0x04/0x05 with status 2 0x06/0x07 above it, control 1 0x08/0x09 with control 2 0x0A/0x0B above it, message 1 0x0C, message 2 0x0D, watchdog count 0x0E, software IRQ 0x10, timeout 0x12/0x13. Unmapped addresses read 0.
- R3: A write to either reload byte loads the counter from the timeout register and restarts the prescaler. Immediately afterwards the reload register reads the loaded value. It then drops by one every TICK_DIV clock cycles.
- R4: The timeout register keeps only its low 10 bits, so writing 0xFF to both bytes makes it read 0x03FF.
- R5: After loading N, the count reads 1 after (N-1) ticks with the timeout flag (status 1 bit 3) still clear. One tick later the flag is set and the counter has reloaded to N.
- R6: Writing 1 to status 1 bit 3 clears the timeout flag. Writing 0 leaves it unchanged.
- R7: An expiry that occurs while the timeout flag is set raises the second-timeout flag (status 2 bit 1) and the boot flag (status 2 bit 2).
- R8: On such a second expiry `reset_req` pulses high for one cycle if `no_reboot` is low. It stays low if `no_reboot` is high.
- R9: Both status 2 flags are write-one-to-clear; writing back the value read leaves status 2 at 0.
- R10: While control 1 bit 11 (halt) is set, the count does not change. Clearing it lets counting resume.
- R11: Writing data-in sets status 1 bit 1 and writing data-out sets status 1 bit 2. Both bytes store the written value, and both flags are write-one-to-clear.
- R12: A count of 0 is idle: it neither decrements nor expires.
- R13: The control, message, watchdog-count and software IRQ bytes read back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 6 | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| no_reboot | input | 1 | Strap that suppresses the reset request |
| reset_req | output | 1 | One-cycle reset request on second timeout |

## Verification
The counter is loaded with random timeouts and sampled after a random number of ticks. This separates an off-by-one in the tick count from a prescaler that does not restart on reload. Directed runs at the largest timeout and at two consecutive expiries show whether masking, reloading and escalation behave correctly. The second-expiry run is repeated with the strap high and with it low, which isolates the reset gating from the flag setting. Random writes to the plain storage bytes, together with writes to the status, mailbox and halt bits, show whether each side effect is tied to its own address.

// File: rtl/wd_pkg.sv
package wd_pkg;
    localparam logic [5:0] A_RLD_L  = 6'h00;
    localparam logic [5:0] A_RLD_H  = 6'h01;
    localparam logic [5:0] A_DIN    = 6'h02;
    localparam logic [5:0] A_DOUT   = 6'h03;
    localparam logic [5:0] A_ST1_L  = 6'h04;
    localparam logic [5:0] A_ST1_H  = 6'h05;
    localparam logic [5:0] A_ST2_L  = 6'h06;
    localparam logic [5:0] A_ST2_H  = 6'h07;
    localparam logic [5:0] A_CTL1_L = 6'h08;
    localparam logic [5:0] A_CTL1_H = 6'h09;
    localparam logic [5:0] A_CTL2_L = 6'h0A;
    localparam logic [5:0] A_CTL2_H = 6'h0B;
    localparam logic [5:0] A_MSG1   = 6'h0C;
    localparam logic [5:0] A_MSG2   = 6'h0D;
    localparam logic [5:0] A_WDCNT  = 6'h0E;
    localparam logic [5:0] A_SWIRQ  = 6'h10;
    localparam logic [5:0] A_TMO_L  = 6'h12;
    localparam logic [5:0] A_TMO_H  = 6'h13;

    // status bit positions within the low byte
    localparam int B_SMI  = 1;
    localparam int B_INT  = 2;
    localparam int B_TMO  = 3;
    localparam int B_SEC  = 1;
    localparam int B_BOOT = 2;
    // halt bit of control 1 (bit 11 -> bit 3 of the high byte)
    localparam int B_HALT = 11;

    localparam logic [15:0] CTL2_RST  = 16'h0008;
    localparam logic [7:0]  SWIRQ_RST = 8'h03;
    localparam int          TMO_RST   = 4;
endpackage

// File: rtl/wd_prescaler.sv
module wd_prescaler #(
    parameter int TICK_DIV = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic hold,
    output logic tick
);
    localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

    logic [PW-1:0] pre_d, pre_q;

    always_comb begin
        tick  = !clear && !hold && (pre_q == LAST);
        pre_d = pre_q;
        if (clear)           pre_d = '0;
        else if (hold)       pre_d = pre_q;
        else if (pre_q == LAST) pre_d = '0;
        else                 pre_d = pre_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end
endmodule

// File: rtl/wd_downcounter.sv
module wd_downcounter #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    input  logic             run,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        expire = !load && tick && run && (cnt_q == ONE);
        cnt_d  = cnt_q;
        if (load)                              cnt_d = load_val;
        else if (expire)                       cnt_d = load_val;
        else if (tick && run && cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;

    // R3
    reload_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(load_val)));

    // R10
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load) |=> $stable(cnt_q));
endmodule

// File: rtl/two_stage_watchdog.sv
module two_stage_watchdog #(
    parameter int TICK_DIV = 1000,
    parameter int CNT_W    = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [5:0] bus_addr,
    input  logic       bus_wr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       no_reboot,
    output logic       reset_req
);
    import wd_pkg::*;

    typedef struct packed {
        logic [CNT_W-1:0] tmo;
        logic [7:0]       din;
        logic [7:0]       dout;
        logic             st1_tmo;
        logic             st1_smi;
        logic             st1_int;
        logic             st2_sec;
        logic             st2_boot;
        logic [15:0]      ctl1;
        logic [15:0]      ctl2;
        logic [7:0]       msg1;
        logic [7:0]       msg2;
        logic [7:0]       wdcnt;
        logic [7:0]       swirq;
        logic             rst_req;
    } regs_t;

    localparam regs_t REGS_RST = '{
        tmo: CNT_W'(TMO_RST), din: '0, dout: '0,
        st1_tmo: 1'b0, st1_smi: 1'b0, st1_int: 1'b0,
        st2_sec: 1'b0, st2_boot: 1'b0,
        ctl1: '0, ctl2: CTL2_RST, msg1: '0, msg2: '0,
        wdcnt: '0, swirq: SWIRQ_RST, rst_req: 1'b0};

    regs_t            r_d, r_q;
    logic             load, tick, expire, halted;
    logic [CNT_W-1:0] count;
    logic [15:0]      tmo_wide;

    assign halted = r_q.ctl1[B_HALT];

    wd_prescaler #(.TICK_DIV(TICK_DIV)) i_pre (
        .clk(clk), .rst_n(rst_n), .clear(load), .hold(halted), .tick(tick));

    wd_downcounter #(.CNT_W(CNT_W)) i_cnt (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(r_q.tmo),
        .tick(tick), .run(!halted), .count(count), .expire(expire));

    always_comb begin
        r_d         = r_q;
        r_d.rst_req = 1'b0;
        load        = 1'b0;
        tmo_wide    = 16'(r_q.tmo);
        if (bus_wr) begin
            case (bus_addr)
                A_RLD_L, A_RLD_H: load = 1'b1;
                A_DIN:    begin r_d.din  = bus_wdata; r_d.st1_smi = 1'b1; end
                A_DOUT:   begin r_d.dout = bus_wdata; r_d.st1_int = 1'b1; end
                A_ST1_L: begin
                    if (bus_wdata[B_TMO]) r_d.st1_tmo = 1'b0;
                    if (bus_wdata[B_SMI]) r_d.st1_smi = 1'b0;
                    if (bus_wdata[B_INT]) r_d.st1_int = 1'b0;
                end
                A_ST2_L: begin
                    if (bus_wdata[B_SEC])  r_d.st2_sec  = 1'b0;
                    if (bus_wdata[B_BOOT]) r_d.st2_boot = 1'b0;
                end
                A_CTL1_L: r_d.ctl1[7:0]  = bus_wdata;
                A_CTL1_H: r_d.ctl1[15:8] = bus_wdata;
                A_CTL2_L: r_d.ctl2[7:0]  = bus_wdata;
                A_CTL2_H: r_d.ctl2[15:8] = bus_wdata;
                A_MSG1:   r_d.msg1  = bus_wdata;
                A_MSG2:   r_d.msg2  = bus_wdata;
                A_WDCNT:  r_d.wdcnt = bus_wdata;
                A_SWIRQ:  r_d.swirq = bus_wdata;
                A_TMO_L: begin
                    tmo_wide[7:0] = bus_wdata;
                    r_d.tmo = tmo_wide[CNT_W-1:0];
                end
                A_TMO_H: begin
                    tmo_wide[15:8] = bus_wdata;
                    r_d.tmo = tmo_wide[CNT_W-1:0];
                end
                default: ;
            endcase
        end
        // an expiry takes priority over a clear in the same cycle
        if (expire) begin
            r_d.st1_tmo = 1'b1;
            if (r_q.st1_tmo) begin
                r_d.st2_sec  = 1'b1;
                r_d.st2_boot = 1'b1;
                r_d.rst_req  = !no_reboot;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= REGS_RST;
        else        r_q <= r_d;
    end

    assign reset_req = r_q.rst_req;

    always_comb begin
        case (bus_addr)
            A_RLD_L:  bus_rdata = count[7:0];
            A_RLD_H:  bus_rdata = 8'(count >> 8);
            A_DIN:    bus_rdata = r_q.din;
            A_DOUT:   bus_rdata = r_q.dout;
            A_ST1_L:  bus_rdata = {4'b0, r_q.st1_tmo, r_q.st1_int, r_q.st1_smi, 1'b0};
            A_ST2_L:  bus_rdata = {5'b0, r_q.st2_boot, r_q.st2_sec, 1'b0};
            A_CTL1_L: bus_rdata = r_q.ctl1[7:0];
            A_CTL1_H: bus_rdata = r_q.ctl1[15:8];
            A_CTL2_L: bus_rdata = r_q.ctl2[7:0];
            A_CTL2_H: bus_rdata = r_q.ctl2[15:8];
            A_MSG1:   bus_rdata = r_q.msg1;
            A_MSG2:   bus_rdata = r_q.msg2;
            A_WDCNT:  bus_rdata = r_q.wdcnt;
            A_SWIRQ:  bus_rdata = r_q.swirq;
            A_TMO_L:  bus_rdata = r_q.tmo[7:0];
            A_TMO_H:  bus_rdata = 8'(r_q.tmo >> 8);
            default:  bus_rdata = 8'h00;
        endcase
    end

    // R8
    reset_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> (r_q.st2_sec && !$past(no_reboot)));

    // R7
    second_needs_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.st2_sec) |-> $past(r_q.st1_tmo));

    // R5
    first_flag_on_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> r_q.st1_tmo);
endmodule

// File: tb/test_two_stage_watchdog.sv
module test_two_stage_watchdog;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       no_reboot = 1'b0;
    logic       reset_req;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    two_stage_watchdog #(.TICK_DIV(DIV), .CNT_W(10)) i_two_stage_watchdog (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .no_reboot(no_reboot), .reset_req(reset_req));

    function automatic int mask_tmo(int v);
        return v & 10'h3FF;
    endfunction

    function automatic int count_after(int n, int k);
        return n - k;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [5:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [5:0] a, output int v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic rd16(logic [5:0] a, output int v);
        int lo, hi;
        rd(a, lo);
        rd(a + 6'd1, hi);
        v = (hi << 8) | lo;
    endtask

    task automatic set_tmo(int n);
        wr(6'h12, 8'(n));
        wr(6'h13, 8'(n >> 8));
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int v, n, k, c0, c1;
        int a_list[5];
        int model[5];
        bit seen;
        void'($urandom(32'h1234));
        a_list = '{6'h0C, 6'h0D, 6'h0E, 6'h10, 6'h0A};
        model  = '{0, 0, 0, 3, 8};

        wait_cyc(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values, R2 pair layout
        rd16(6'h00, v); check("R1 reload", v, 16'h0000);
        rd16(6'h02, v); check("R1 data bytes", v, 16'h0000);
        rd16(6'h04, v); check("R1 status1", v, 0);
        rd16(6'h06, v); check("R1 status2", v, 0);
        rd16(6'h08, v); check("R1 ctl1", v, 0);
        rd16(6'h0A, v); check("R1 R2 ctl2 high half", v, 16'h0008);
        rd16(6'h0C, v); check("R1 message", v, 0);
        rd(6'h0E, v);   check("R1 wdcnt", v, 0);
        rd(6'h10, v);   check("R1 swirq", v, 8'h03);
        rd16(6'h12, v); check("R1 timeout", v, 16'h0004);
        rd(6'h3F, v);   check("R2 unmapped", v, 0);

        // R12 idle count of zero never expires
        wait_cyc(10 * DIV);
        rd16(6'h00, v); check("R12 idle count", v, 0);
        rd(6'h04, v);   check("R12 no flag", v, 0);

        // R4 masking
        set_tmo(16'hFFFF);
        rd16(6'h12, v); check("R4 mask", v, mask_tmo(16'hFFFF));

        // R5 max timeout
        wr(6'h00, 8'h00);
        rd16(6'h00, v); check("R3 loaded max", v, 16'h03FF);
        wait_cyc((16'h3FF - 1) * DIV);
        rd16(6'h00, v); check("R5 count one", v, 1);
        rd(6'h04, v);   check("R5 flag still clear", v & 8'h08, 0);
        wait_cyc(DIV);
        rd(6'h04, v);   check("R5 flag set", v & 8'h08, 8'h08);
        rd16(6'h00, v); check("R5 reloaded", v, 16'h03FF);

        // R6 writing 0 keeps flag, writing 1 clears
        wr(6'h04, 8'h00);
        rd(6'h04, v); check("R6 zero write no effect", v & 8'h08, 8'h08);
        wr(6'h04, 8'h08);
        rd(6'h04, v); check("R6 cleared", v & 8'h08, 0);

        // R3 random timeouts and tick counts
        for (int i = 0; i < 20; i++) begin
            n = 2 + ($urandom % 11);
            k = 1 + ($urandom % (n - 1));
            set_tmo(n);
            wr(6'h04, 8'h08);
            wr(6'h01, 8'hA5);
            rd16(6'h00, v); check("R3 immediate read", v, n);
            wait_cyc(k * DIV);
            rd16(6'h00, v); check("R3 decrement", v, count_after(n, k));
            rd(6'h04, v);   check("R3 no early flag", v & 8'h08, 0);
        end

        // R7 R8 second expiry with reset request
        set_tmo(3);
        wr(6'h04, 8'h0E);
        wr(6'h06, 8'h06);
        no_reboot = 1'b0;
        wr(6'h00, 8'h00);
        wait_cyc(3 * DIV);
        rd(6'h04, v);    check("R7 first flag", v & 8'h08, 8'h08);
        rd(6'h06, v);    check("R7 no second yet", v, 0);
        wait_cyc(3 * DIV);
        check("R8 reset pulse", reset_req, 1);
        rd(6'h06, v);    check("R7 second and boot", v, 8'h06);
        wait_cyc(1);
        check("R8 pulse one cycle", reset_req, 0);

        // R9 write back status 2
        rd(6'h06, v);
        wr(6'h06, 8'(v));
        rd16(6'h06, v);  check("R9 status2 clear", v, 0);

        // R8 strap suppresses reset
        wr(6'h04, 8'h08);
        no_reboot = 1'b1;
        wr(6'h00, 8'h00);
        seen = 1'b0;
        for (int i = 0; i < 6 * DIV + 2; i++) begin
            @(negedge clk);
            if (reset_req) seen = 1'b1;
        end
        check("R8 suppressed", seen, 0);
        rd(6'h06, v);    check("R8 flags still set", v, 8'h06);
        no_reboot = 1'b0;
        wr(6'h06, 8'h06);

        // R10 halt
        set_tmo(40);
        wr(6'h00, 8'h00);
        wait_cyc(2 * DIV);
        wr(6'h09, 8'h08);
        rd16(6'h00, c0);
        wait_cyc(8 * DIV);
        rd16(6'h00, c1); check("R10 halted", c1, c0);
        wr(6'h09, 8'h00);
        wait_cyc(3 * DIV);
        rd16(6'h00, v);  check("R10 resumed", (v < c0) ? 1 : 0, 1);

        // R11 mailbox bytes
        wr(6'h04, 8'h0E);
        wr(6'h02, 8'h5A);
        rd(6'h04, v);   check("R11 smi flag", v & 8'h06, 8'h02);
        wr(6'h03, 8'hC3);
        rd(6'h04, v);   check("R11 int flag", v & 8'h06, 8'h06);
        rd16(6'h02, v); check("R11 R2 data pair", v, 16'hC35A);
        wr(6'h04, 8'h06);
        rd(6'h04, v);   check("R11 cleared", v & 8'h06, 0);

        // R13 random storage writes
        for (int i = 0; i < 30; i++) begin
            int s, d;
            s = $urandom % 5;
            d = $urandom % 256;
            wr(6'(a_list[s]), 8'(d));
            model[s] = d;
            for (int j = 0; j < 5; j++) begin
                rd(6'(a_list[j]), v);
                check("R13 storage", v, model[j]);
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule